// File: doc/BRIEF.md
# Write-Protection and Status Controller

This block sits behind the command decoder of a serial EEPROM-style memory. It owns the write-enable latch and the status register, and tells the rest of the device whether a program operation on a given array address, or an update of the status register itself, may go ahead. The decoder raises one-cycle requests to set or clear the latch. It presents status-write data while chip select is low, and it supplies the address that a pending array write targets. An external cycle timer drives the busy input.

Protection has two layers. A two-bit level field fences off nothing, the top quarter, the top half or all of the array. A lock bit makes the active-low write-protect pin able to freeze the status register. A status write is captured while the frame is open and takes effect only when chip select rises. The level and lock bits survive a soft reset and are cleared only by the asynchronous power-on reset.

Top module: `prot_status_unit`

## Requirements
- R1: While busy_i is 0, status_o carries the lock bit in bit 7, zeros in bits 6 to 4, the level field in bits 3:2 (bit 3 is the high bit), the latch in bit 1 and 0 in bit 0.
- R2: While busy_i is 1, status_o reads 8'hFF and both arr_wr_ok_o and sr_wr_ok_o are 0.
- R3: After power-on reset the latch, the lock bit and the level field are all 0, so status_o is 8'h00.
- R4: A set request writes 1 to the latch and a clear request writes 0, in the cycle after the request. When both come together, the clear wins.
- R5: A falling edge on busy_i clears the latch.
- R6: arr_wr_ok_o is 1 only when the latch is set, busy_i is 0 and the address is outside the protected range. Level 00 protects nothing, 01 protects addresses at or above three quarters of the space, 10 protects the upper half and 11 protects every address.
- R7: A status write is accepted when the request arrives with cs_ni low, the latch set and sr_wr_ok_o high. It is committed on the clock after cs_ni rises. It changes only bits 7, 3 and 2, and it raises sr_start_o for exactly one cycle.
- R8: When wp_ni is 0 and the lock bit is 1, sr_wr_ok_o is 0 and status writes are refused, including writes that would clear the lock bit. When the lock bit is 0, wp_ni has no effect.
- R9: If the hardware lock becomes active while an accepted status write is still waiting for cs_ni to rise, that write is dropped, even if the lock is released before cs_ni rises.
- R10: soft_rst_i clears the latch and any waiting status write but keeps the lock bit and the level field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| soft_rst_i | input | 1 | Synchronous soft reset; clears the latch and any waiting status write |
| cs_ni | input | 1 | Chip select, active low; a rising edge commits a waiting status write |
| wp_ni | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Internal program cycle in progress |
| wel_set_i | input | 1 | Request to set the write-enable latch |
| wel_clr_i | input | 1 | Request to clear the write-enable latch |
| sr_wr_req_i | input | 1 | Status-write data valid this cycle |
| sr_wr_data_i | input | 8 | Status-write data byte |
| addr_i | input | ADDR_W | Array address to be checked |
| status_o | output | 8 | Status byte for reads |
| arr_wr_ok_o | output | 1 | Array write to addr_i permitted |
| sr_wr_ok_o | output | 1 | Status write permitted |
| sr_start_o | output | 1 | One-cycle pulse: a status write was committed and the program cycle should start |

## Verification
The checker enforces the rules that hold on every cycle: the all-ones byte and dead permits while busy, the zero pad bits when idle, the latch falling after busy drops, the whole-array level blocking every address, the hardware lock holding off status writes, the nonvolatile bits changing only alongside a start pulse, and the soft reset leaving them alone. The bench scenarios cover the ordered behaviour that no single-cycle rule can show. These are capture at the request and commit at the rising edge of chip select, the drop of a waiting write when the lock appears mid-frame, the latch priority when set and clear coincide, and a sweep of addresses across every level with the boundary addresses.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int SR_W   = 8;
  localparam int B_LOCK = 7;
  localparam int B_LVH  = 3;
  localparam int B_LVL  = 2;
  localparam int B_WEL  = 1;
  localparam int B_BUSY = 0;

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_QTR  = 2'b01,
    LVL_HALF = 2'b10,
    LVL_ALL  = 2'b11
  } prot_lvl_e;

  function automatic logic [SR_W-1:0] pack_status(logic lock, prot_lvl_e lvl,
                                                  logic wel, logic busy);
    logic [SR_W-1:0] s;
    s = '0;
    s[B_LOCK] = lock;
    s[B_LVH]  = lvl[1];
    s[B_LVL]  = lvl[0];
    s[B_WEL]  = wel;
    if (busy) s = '1;
    return s;
  endfunction
endpackage

// File: rtl/prot_addr_map.sv
module prot_addr_map
  import prot_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  prot_lvl_e         lvl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] QTR_BASE  = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

  always_comb begin
    unique case (lvl_i)
      LVL_QTR:  hit_o = (addr_i >= QTR_BASE);
      LVL_HALF: hit_o = (addr_i >= HALF_BASE);
      LVL_ALL:  hit_o = 1'b1;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/prot_wel.sv
module prot_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic busy_i,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  logic busy_q, wel_q;
  logic busy_fall;

  assign busy_fall = busy_q & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (soft_rst_i || busy_fall) wel_q <= 1'b0;
      else if (!busy_i) begin
        if (clr_i)      wel_q <= 1'b0;
        else if (set_i) wel_q <= 1'b1;
      end
    end
  end

  assign wel_o = wel_q;
endmodule

// File: rtl/prot_sr_write.sv
module prot_sr_write
  import prot_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            soft_rst_i,
  input  logic            cs_ni,
  input  logic            wp_ni,
  input  logic            busy_i,
  input  logic            wel_i,
  input  logic            req_i,
  input  logic [SR_W-1:0] data_i,
  output logic            lock_o,
  output prot_lvl_e       lvl_o,
  output logic            permit_o,
  output logic            start_o
);
  logic      cs_q, pend_q, start_q, lock_q;
  prot_lvl_e lvl_q;
  logic [2:0] data_q;
  logic hw_lock, cs_rise, permit, commit;
  logic unused_data;

  assign unused_data = ^{data_i[6:4], data_i[1:0]};
  assign hw_lock = ~wp_ni & lock_q;
  assign cs_rise = cs_ni & ~cs_q;
  assign permit  = wel_i & ~busy_i & ~hw_lock;
  assign commit  = cs_rise & pend_q & permit & ~soft_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b1;
      pend_q  <= 1'b0;
      data_q  <= '0;
      start_q <= 1'b0;
    end else begin
      cs_q    <= cs_ni;
      start_q <= commit;
      // lock appearing mid-frame drops the captured write
      if (soft_rst_i || hw_lock || cs_rise) pend_q <= 1'b0;
      else if (req_i && !cs_ni && permit) begin
        pend_q <= 1'b1;
        data_q <= {data_i[B_LOCK], data_i[B_LVH], data_i[B_LVL]};
      end
    end
  end

  // nonvolatile image: power-on reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      lvl_q  <= LVL_NONE;
    end else if (commit) begin
      lock_q <= data_q[2];
      lvl_q  <= prot_lvl_e'(data_q[1:0]);
    end
  end

  assign lock_o   = lock_q;
  assign lvl_o    = lvl_q;
  assign permit_o = permit;
  assign start_o  = start_q;
endmodule

// File: rtl/prot_status_unit.sv
module prot_status_unit
  import prot_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              cs_ni,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              sr_wr_req_i,
  input  logic [SR_W-1:0]   sr_wr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SR_W-1:0]   status_o,
  output logic              arr_wr_ok_o,
  output logic              sr_wr_ok_o,
  output logic              sr_start_o
);
  logic      wel;
  logic      nv_lock;
  prot_lvl_e nv_lvl;
  logic      addr_hit;

  prot_wel u_wel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .busy_i     (busy_i),
    .set_i      (wel_set_i),
    .clr_i      (wel_clr_i),
    .wel_o      (wel)
  );

  prot_sr_write u_srw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .cs_ni      (cs_ni),
    .wp_ni      (wp_ni),
    .busy_i     (busy_i),
    .wel_i      (wel),
    .req_i      (sr_wr_req_i),
    .data_i     (sr_wr_data_i),
    .lock_o     (nv_lock),
    .lvl_o      (nv_lvl),
    .permit_o   (sr_wr_ok_o),
    .start_o    (sr_start_o)
  );

  prot_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .lvl_i  (nv_lvl),
    .addr_i (addr_i),
    .hit_o  (addr_hit)
  );

  assign arr_wr_ok_o = wel & ~busy_i & ~addr_hit;
  assign status_o    = pack_status(nv_lock, nv_lvl, wel, busy_i);
endmodule

// File: rtl/prot_status_chk.sv
module prot_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       wp_ni,
  input logic       busy_i,
  input logic [7:0] status_o,
  input logic       arr_wr_ok_o,
  input logic       sr_wr_ok_o,
  input logic       sr_start_o,
  input logic       wel,
  input logic       nv_lock,
  input logic [1:0] nv_lvl
);
  assert_idle_pad_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (status_o[6:4] == 3'b000 && !status_o[0]));

  assert_busy_ff_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (status_o == 8'hFF && !arr_wr_ok_o && !sr_wr_ok_o));

  assert_wel_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |=> !wel);

  assert_full_prot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_lvl == 2'b11) |-> !arr_wr_ok_o);

  assert_nv_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_lvl != $past(nv_lvl) || nv_lock != $past(nv_lock)) |-> sr_start_o);

  assert_hw_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_ni && nv_lock) |-> !sr_wr_ok_o);

  assert_soft_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!wel && $stable(nv_lvl) && $stable(nv_lock)));
endmodule

bind prot_status_unit prot_status_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .wp_ni       (wp_ni),
  .busy_i      (busy_i),
  .status_o    (status_o),
  .arr_wr_ok_o (arr_wr_ok_o),
  .sr_wr_ok_o  (sr_wr_ok_o),
  .sr_start_o  (sr_start_o),
  .wel         (wel),
  .nv_lock     (nv_lock),
  .nv_lvl      (nv_lvl)
);

// File: tb/tb_prot_status_unit.sv
module tb_prot_status_unit;
  localparam int AW = 17;
  localparam longint WD_NS = 64'd200000 * 20;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, cs_n = 1'b1, wp_n = 1'b1;
  logic busy = 1'b0, wset = 1'b0, wclr = 1'b0, req = 1'b0;
  logic [7:0] wdata = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] status;
  logic arr_ok, sr_ok, sr_start;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prot_status_unit #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .cs_ni(cs_n), .wp_ni(wp_n),
    .busy_i(busy), .wel_set_i(wset), .wel_clr_i(wclr), .sr_wr_req_i(req),
    .sr_wr_data_i(wdata), .addr_i(addr), .status_o(status), .arr_wr_ok_o(arr_ok),
    .sr_wr_ok_o(sr_ok), .sr_start_o(sr_start)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wel_req(input logic s, input logic c);
    @(negedge clk); wset = s; wclr = c;
    @(negedge clk); wset = 0; wclr = 0;
  endtask

  // full frame; runs a short program cycle if committed
  task automatic sr_write(input logic [7:0] d, output logic started);
    @(negedge clk); cs_n = 0;
    @(negedge clk); req = 1; wdata = d;
    @(negedge clk); req = 0; cs_n = 1;
    @(negedge clk); started = sr_start;
    if (started) begin
      busy = 1; #1;
      chk("R2 status while busy", status, 8'hFF);
      chk("R2 permits while busy", {arr_ok, sr_ok}, 0);
      @(negedge clk);
      chk("R7 start pulse one cycle", sr_start, 0);
      repeat (2) @(negedge clk);
      busy = 0;
      @(negedge clk);
    end
  endtask

  function automatic logic exp_prot(input int lvl, input int a);
    case (lvl)
      1: return a >= 3 * (1 << (AW - 2));
      2: return a >= (1 << (AW - 1));
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #(WD_NS);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic st;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset status", status, 8'h00);
    chk("R3 reset permits", {arr_ok, sr_ok}, 0);

    wel_req(1, 0); chk("R4 set latch", status, 8'h02);
    chk("R6 unprotected addr ok", arr_ok, 1);
    wel_req(0, 1); chk("R4 clear latch", status, 8'h00);
    wel_req(1, 0); wel_req(1, 1); chk("R4 clear wins", status, 8'h00);

    sr_write(8'h8C, st);
    chk("R7 refused without latch", st, 0);
    chk("R7 no change without latch", status, 8'h00);

    wel_req(1, 0);
    sr_write(8'h7F, st);
    chk("R7 committed", st, 1);
    chk("R1 R5 pad bits and latch after cycle", status, 8'h0C);

    wel_req(1, 0); sr_write(8'h80, st);
    chk("R7 lock bit written", status, 8'h80);
    wel_req(1, 0);
    wp_n = 0; #1;
    chk("R8 locked permit", sr_ok, 0);
    sr_write(8'h0C, st);
    chk("R8 locked refused", st, 0);
    chk("R8 locked status kept", status, 8'h82);
    addr = 0; #1;
    chk("R8 array still writable", arr_ok, 1);
    wp_n = 1; #1;
    chk("R8 pin high permit", sr_ok, 1);

    @(negedge clk); cs_n = 0;
    @(negedge clk); req = 1; wdata = 8'h04;
    @(negedge clk); req = 0; wp_n = 0;
    @(negedge clk); wp_n = 1;
    @(negedge clk); cs_n = 1;
    @(negedge clk);
    chk("R9 no start after mid-frame lock", sr_start, 0);
    chk("R9 status unchanged", status, 8'h82);

    sr_write(8'h00, st);
    chk("R8 unlock committed", st, 1);
    wp_n = 0;
    wel_req(1, 0); #1;
    chk("R8 pin ignored when unlocked", sr_ok, 1);
    sr_write(8'h08, st);
    chk("R8 write with pin low", status, 8'h08);
    wp_n = 1;

    wel_req(1, 0);
    chk("R10 pre soft reset", status, 8'h0A);
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    chk("R10 soft reset keeps level", status, 8'h08);

    for (int lvl = 0; lvl < 4; lvl++) begin
      wel_req(1, 0);
      sr_write(8'(lvl << 2), st);
      chk("R7 level write", status, 32'(lvl << 2));
      for (int k = 0; k < 64; k++) begin
        int a;
        a = k * 2048 + ((k * 37) % 2048);
        addr = AW'(a); #1;
        chk("R6 no latch no write", arr_ok, 0);
      end
      wel_req(1, 0);
      for (int k = 0; k < 70; k++) begin
        int a;
        case (k)
          64: a = 'h17FFF; 65: a = 'h18000; 66: a = 'hFFFF;
          67: a = 'h10000; 68: a = 'h1FFFF; 69: a = 0;
          default: a = k * 2048 + ((k * 37) % 2048);
        endcase
        addr = AW'(a); #1;
        chk("R6 protection map", arr_ok, !exp_prot(lvl, a));
      end
    end

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R3 power-on reset clears level", status, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule